// File: doc/BRIEF.md
# Register-Modification Recovery Logger

This block keeps a short history of the automatic register increments and decrements that the current instruction has made. If the instruction is later aborted, a fault handler reads the history and backs out each change. The history is a 16-bit readable word built from two byte-wide entries. Each entry packs a signed 5-bit change amount above a 3-bit register number.

The first accepted change of an instruction fills the low byte and the second fills the high byte. A write-count state bit picks the byte, so two changes to the same register always stay as two entries and are never added together. Each change is offered with a `log_valid` strobe together with a register number, a direction flag and an operand-size flag. The block computes the amount itself: 1 for byte operands, 2 for word operands, and always 2 when the register is the stack pointer (6) or the program counter (7).

`log_ready` gives the acceptance rule. A strobe is taken in any cycle where `log_valid` and `log_ready` are both high. A strobe offered while `log_ready` is low is dropped, and the producer does not need to hold it, because the logger never stalls the pipeline. `instr_start` marks the first cycle of each instruction and clears the history. `freeze` comes from the error bits of the companion status register and holds the history unchanged for as long as it is high.

Top module: `rmr_logger`

## Requirements
- R1: After reset, `log_word` reads 0 and `log_ready` is high.
- R2: Each entry holds its signed change amount in entry bits 7:3 and the register number in entry bits 2:0. The high entry sits in `log_word` bits 15:8 and the low entry in bits 7:0.
- R3: The first accepted change of an instruction is written to bits 7:0 and leaves bits 15:8 at zero. The second accepted change is written to bits 15:8 and leaves bits 7:0 unchanged. `log_word` shows each change in the cycle after the edge that accepts it.
- R4: Two changes to the same register are kept as two separate entries. For example, +2 on register 7 twice reads octal 013427, never octal 000047.
- R5: The amount is 2 for word operands (`log_byte`=0) and 1 for byte operands on registers 0 to 5. It is always 2 for registers 6 and 7. When `log_dec`=1 the amount is negated and stored in two's complement (for example, -2 is 5'b11110).
- R6: Once two changes have been logged in an instruction, `log_ready` is low. A further strobe is ignored and `log_word` does not change.
- R7: `instr_start` with `freeze` low clears both entries and the write count, so `log_word` reads 0 in the next cycle unless a change is accepted in the same cycle.
- R8: While `freeze` is high, `log_ready` is low and `log_word` holds its value. Strobes and `instr_start` are ignored.
- R9: A change offered in the same cycle as `instr_start`, with `freeze` low, is accepted as the first entry of the new instruction. It lands in bits 7:0 and bits 15:8 are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_start | input | 1 | First cycle of a new instruction; clears the history |
| freeze | input | 1 | High while the companion status register has an error bit set |
| log_valid | input | 1 | A register change is offered this cycle |
| log_ready | output | 1 | The offered change will be accepted this cycle |
| log_reg | input | 3 | Number of the register that changed |
| log_dec | input | 1 | 1 for a decrement, 0 for an increment |
| log_byte | input | 1 | 1 for a byte operand, 0 for a word operand |
| log_word | output | 16 | Readable history: high entry in bits 15:8, low entry in bits 7:0 |

## Verification
Directed sequences cover four cases:
- The same register changed twice (octal 013427), which separates two entries from a summed one.
- Two different registers, which shows byte order.
- A byte-operand decrement on registers below 6 against the stack pointer, which shows the amount rule and the two's-complement encoding.
- Sequences with a frozen history, a third strobe, and a strobe coinciding with `instr_start`, which show whether state holds, is dropped, or restarts.

A seeded random mix of strobes, starts and freezes is then compared each cycle against a bench model of the history word and of `log_ready`. This exposes ordering and priority slips that the directed cases miss.

// File: rtl/rmr_pkg.sv
package rmr_pkg;
  localparam int unsigned RMR_REG_W  = 3;
  localparam int unsigned RMR_AMT_W  = 5;
  localparam int unsigned RMR_SLOTS  = 2;
  localparam int unsigned RMR_SP_IDX = 6;

  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_CLEAR   = 2'd1,
    OP_LOG     = 2'd2,
    OP_RESTART = 2'd3
  } rmr_op_e;
endpackage

// File: rtl/rmr_step_calc.sv
module rmr_step_calc #(
  parameter int unsigned REG_W  = 3,
  parameter int unsigned AMT_W  = 5,
  parameter int unsigned SP_IDX = 6
) (
  input  logic [REG_W-1:0] reg_idx,
  input  logic             dec,
  input  logic             byte_op,
  output logic [AMT_W-1:0] amount
);
  logic [AMT_W-1:0] mag;

  always_comb begin
    // stack pointer and PC always move by a full word
    if (byte_op && (int'(reg_idx) < int'(SP_IDX))) mag = AMT_W'(1);
    else                                           mag = AMT_W'(2);
    amount = dec ? (~mag + AMT_W'(1)) : mag;
  end

  // R5: amount is always plus or minus 1 or 2
  always_comb begin
    a_r5_amount_range : assert (amount == AMT_W'(1) || amount == AMT_W'(2) ||
                                amount == ~AMT_W'(0) || amount == ~AMT_W'(1));
  end
endmodule

// File: rtl/rmr_slot_ctrl.sv
module rmr_slot_ctrl
  import rmr_pkg::*;
#(
  parameter int unsigned SLOTS = 2,
  localparam int unsigned CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_start,
  input  logic             freeze,
  input  logic             log_valid,
  output logic             log_ready,
  output rmr_op_e          op,
  output logic [SLOTS-1:0] slot_sel,
  output logic [CNT_W-1:0] cnt
);
  logic             full;
  logic             accept;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    full      = (cnt >= CNT_W'(SLOTS));
    log_ready = !freeze && (instr_start || !full);
    accept    = log_valid && log_ready;
    if (freeze)                      op = OP_IDLE;
    else if (instr_start && accept)  op = OP_RESTART;
    else if (instr_start)            op = OP_CLEAR;
    else if (accept)                 op = OP_LOG;
    else                             op = OP_IDLE;
    target = (op == OP_RESTART) ? '0 : cnt;
    unique case (op)
      OP_CLEAR:   cnt_nxt = '0;
      OP_RESTART: cnt_nxt = CNT_W'(1);
      OP_LOG:     cnt_nxt = cnt + CNT_W'(1);
      default:    cnt_nxt = cnt;
    endcase
  end

  for (genvar s = 0; s < int'(SLOTS); s++) begin : g_sel
    assign slot_sel[s] = (target == CNT_W'(s)) &&
                         (op == OP_LOG || op == OP_RESTART);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  a_r6_count_bounded : assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(SLOTS));
  a_r8_count_frozen : assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(cnt));
  a_r6_sel_onehot : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_sel));
endmodule

// File: rtl/rmr_logger.sv
module rmr_logger
  import rmr_pkg::*;
#(
  parameter int unsigned REG_W  = RMR_REG_W,
  parameter int unsigned AMT_W  = RMR_AMT_W,
  parameter int unsigned SLOTS  = RMR_SLOTS,
  parameter int unsigned SP_IDX = RMR_SP_IDX,
  localparam int unsigned ENT_W  = AMT_W + REG_W,
  localparam int unsigned WORD_W = ENT_W * SLOTS,
  localparam int unsigned CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_start,
  input  logic              freeze,
  input  logic              log_valid,
  output logic              log_ready,
  input  logic [REG_W-1:0]  log_reg,
  input  logic              log_dec,
  input  logic              log_byte,
  output logic [WORD_W-1:0] log_word
);
  rmr_op_e          op;
  logic [SLOTS-1:0] slot_sel;
  logic [CNT_W-1:0] cnt;
  logic [AMT_W-1:0] amount;
  logic [ENT_W-1:0] new_ent;

  rmr_step_calc #(.REG_W(REG_W), .AMT_W(AMT_W), .SP_IDX(SP_IDX)) u_step (
    .reg_idx (log_reg),
    .dec     (log_dec),
    .byte_op (log_byte),
    .amount  (amount)
  );

  rmr_slot_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_start (instr_start),
    .freeze      (freeze),
    .log_valid   (log_valid),
    .log_ready   (log_ready),
    .op          (op),
    .slot_sel    (slot_sel),
    .cnt         (cnt)
  );

  assign new_ent = {amount, log_reg};

  for (genvar s = 0; s < int'(SLOTS); s++) begin : g_ent
    logic [ENT_W-1:0] ent;
    always_ff @(posedge clk) begin
      if (!rst_n) ent <= '0;
      else begin
        unique case (op)
          OP_CLEAR:   ent <= '0;
          OP_RESTART: ent <= slot_sel[s] ? new_ent : '0;
          OP_LOG:     if (slot_sel[s]) ent <= new_ent;
          default:    ;
        endcase
      end
    end
    assign log_word[s*ENT_W +: ENT_W] = ent;
  end

  a_r8_frozen_hold : assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(log_word));
  a_r7_start_clears : assert property (@(posedge clk) disable iff (!rst_n)
    (instr_start && !freeze && !log_valid) |=> (log_word == '0));
  a_r6_full_drop : assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(SLOTS) && !instr_start) |=> $stable(log_word));
  a_r3_first_keeps_high : assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && log_valid && log_ready && !instr_start)
      |=> $stable(log_word[WORD_W-1:ENT_W]));
  a_r9_restart_low : assert property (@(posedge clk) disable iff (!rst_n)
    (instr_start && log_valid && !freeze) |=> (cnt == CNT_W'(1)));
endmodule

// File: tb/test_rmr_logger.sv
module test_rmr_logger;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_start, freeze, log_valid, log_dec, log_byte;
  logic [2:0]  log_reg;
  logic        log_ready;
  logic [15:0] log_word;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_word;
  int          m_cnt;
  bit          done = 0;

  always #5 clk = ~clk;

  rmr_logger i_rmr_logger (
    .clk(clk), .rst_n(rst_n), .instr_start(instr_start), .freeze(freeze),
    .log_valid(log_valid), .log_ready(log_ready), .log_reg(log_reg),
    .log_dec(log_dec), .log_byte(log_byte), .log_word(log_word)
  );

  function automatic logic [7:0] mk_ent(input logic [2:0] r, input logic d, input logic b);
    logic [4:0] a;
    a = (b && r < 3'd6) ? 5'd1 : 5'd2;
    if (d) a = 5'd0 - a;
    return {a, r};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %06o expected %06o", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check ready, step model, check word at next negedge
  task automatic cyc(input string req, input logic st, input logic fz, input logic v,
                     input logic [2:0] r, input logic d, input logic b);
    bit rdy;
    instr_start = st; freeze = fz; log_valid = v; log_reg = r; log_dec = d; log_byte = b;
    #1;
    rdy = !fz && (st || m_cnt < 2);
    chk({req, " ready"}, {15'd0, log_ready}, {15'd0, rdy});
    if (!fz) begin
      if (st) begin m_word = 16'd0; m_cnt = 0; end
      if (v && rdy) begin
        if (m_cnt == 0) m_word[7:0] = mk_ent(r, d, b);
        else            m_word[15:8] = mk_ent(r, d, b);
        m_cnt++;
      end
    end
    @(negedge clk);
    chk({req, " word"}, log_word, m_word);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; instr_start = 0; freeze = 0; log_valid = 0;
    log_reg = 0; log_dec = 0; log_byte = 0;
    m_word = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset word", log_word, 16'd0);
    chk("R1 reset ready", {15'd0, log_ready}, 16'd1);

    // R4: same register twice, octal 013427
    cyc("R4", 1, 0, 0, 0, 0, 0);
    cyc("R3", 0, 0, 1, 3'd7, 0, 0);
    chk("R2 first entry", log_word, 16'o000027);
    cyc("R4", 0, 0, 1, 3'd7, 0, 0);
    chk("R4 same reg", log_word, 16'o013427);
    // R6: third strobe ignored
    cyc("R6", 0, 0, 1, 3'd1, 0, 0);
    chk("R6 third dropped", log_word, 16'o013427);
    // R7: clear
    cyc("R7", 1, 0, 0, 0, 0, 0);
    chk("R7 cleared", log_word, 16'd0);
    // R3/R5: different registers, byte dec on r2, byte op on sp
    cyc("R5", 0, 0, 1, 3'd2, 1, 1);
    chk("R5 byte dec r2", log_word, 16'h00FA);
    cyc("R5", 0, 0, 1, 3'd6, 1, 1);
    chk("R5 sp byte dec", log_word, 16'hF6FA);
    // R8: freeze holds against strobe and start
    cyc("R8", 1, 1, 1, 3'd3, 0, 1);
    chk("R8 frozen", log_word, 16'hF6FA);
    cyc("R8", 0, 1, 0, 0, 0, 0);
    // R9: start with strobe
    cyc("R9", 1, 0, 1, 3'd3, 0, 1);
    chk("R9 restart", log_word, 16'h000B);

    for (int i = 0; i < 400; i++) begin
      cyc("R3 random", ($urandom % 5) == 0, ($urandom % 7) == 0, ($urandom % 3) != 0,
          3'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule